// File: doc/BRIEF.md
# Two-Deep Taskfile Address Register File

This block is the host-facing register file for the addressing part of a disk interface taskfile. Four addressing registers (sector count, LBA low, LBA mid, LBA high) each keep a two-entry history: every write pushes the new byte into the newest slot and moves the byte that was there into the older slot. With the four older slots the host can build a 48-bit block address and a 16-bit sector count out of plain 8-bit register writes, written older byte first.

The host reaches the registers through one 8-bit port with a 3-bit register address, a command-block select, a control-block select and separate read and write strobes. A control register holds a select bit (bit 7 by default) that decides whether a read of an addressing register returns the newest or the older byte. Any write into the command block clears that bit again. All newest and older bytes are also driven in parallel, together with the assembled 48-bit address and 16-bit count, so a command decoder can consume them without going through the host port.

Top module: `hist_taskfile_regs`

## Requirements
- R1: While reset is active and after it, every newest and older slot, the control register and the read data are all zero.
- R2: A command-block write to address 2 (count), 3 (LBA low), 4 (LBA mid) or 5 (LBA high) makes, one clock later, that register's newest slot equal to the written byte and its older slot equal to the newest byte it had before.
- R3: With control bit 7 at 0, a command-block read of addresses 2 to 5 returns the newest slot of that register on the read data, valid from the clock edge that samples the read strobe.
- R4: With control bit 7 at 1, a command-block read of addresses 2 to 5 returns the older slot of that register.
- R5: A command-block write to any of the eight addresses clears control bit 7 and leaves the other control bits unchanged.
- R6: A control-block write loads the whole control byte regardless of address, and a control-block read returns the control byte.
- R7: Reads change no slot and no control bit.
- R8: Command-block writes to addresses 0, 1, 6 and 7 change no slot, and command-block reads of those addresses return zero.
- R9: The parallel outputs pack register k (0 count, 1 LBA low, 2 LBA mid, 3 LBA high) at bits 8k+7..8k; the 48-bit address is {older high, older mid, older low, newest high, newest mid, newest low} and the 16-bit count is {older count, newest count}.
- R10: An access with both selects active, or with neither, is ignored: no slot or control bit changes and the read data holds its value.
- R11: A read and a write in the same cycle are both performed; the read returns the contents from before that write.
- R12: A write to one addressing register leaves the slots of the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_cmd_i | input | 1 | Command-block select |
| cs_ctl_i | input | 1 | Control-block select |
| addr_i | input | 3 | Register address within the command block |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe, one access per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| devctl_o | output | 8 | Control register contents |
| hob_o | output | 1 | Older-byte select bit of the control register |
| cur_o | output | 32 | Newest slots of the four addressing registers |
| prev_o | output | 32 | Older slots of the four addressing registers |
| lba_o | output | 48 | Assembled 48-bit block address |
| count_o | output | 16 | Assembled 16-bit sector count |

## Verification
A read and a write can share a cycle, and a command-block write both shifts a history and clears the older-byte select in that same edge. The bench raises both strobes together on addressing registers while the select bit is set and while it is clear, and expects the read data to show the byte (newest or older, per the select bit as it stood before the edge) from before the shift, while the history and the control bit take their post-write values. Random sequences mixing control writes with command writes confirm that a select bit set by one access is cleared by the very next command write and never leaks into a later read.

// File: rtl/tfh_pkg.sv
package tfh_pkg;

   // number of addressing registers that keep a history
   localparam int unsigned TFH_NREG = 4;

   // history register index, also its offset from the base address
   typedef enum logic [1:0] {
      TFH_CNT     = 2'd0,
      TFH_LBA_LO  = 2'd1,
      TFH_LBA_MID = 2'd2,
      TFH_LBA_HI  = 2'd3
   } tfh_reg_e;

   // which block a host access is aimed at
   typedef enum logic [1:0] {
      TFH_ACC_NONE = 2'd0,
      TFH_ACC_CMD  = 2'd1,
      TFH_ACC_CTL  = 2'd2
   } tfh_acc_e;

endpackage

// File: rtl/tfh_host_decode.sv
module tfh_host_decode
   import tfh_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned BASE_ADDR = 2
) (
   input  logic              cs_cmd_i,
   input  logic              cs_ctl_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output tfh_acc_e          acc_o,
   output logic              hist_hit_o,
   output logic [1:0]        hist_idx_o,
   output logic              cmd_wr_o,
   output logic              ctl_wr_o,
   output logic              rd_go_o,
   output logic [TFH_NREG-1:0] hist_we_o
);

   localparam int unsigned OFF_W = ADDR_W + 1;

   logic [OFF_W-1:0] offset;

   always_comb begin
      unique case ({cs_ctl_i, cs_cmd_i})
         2'b01:   acc_o = TFH_ACC_CMD;
         2'b10:   acc_o = TFH_ACC_CTL;
         default: acc_o = TFH_ACC_NONE;
      endcase
   end

   // an address below the base wraps to a value of at least 2**ADDR_W
   assign offset     = {1'b0, addr_i} - OFF_W'(BASE_ADDR);
   assign hist_hit_o = (offset < OFF_W'(TFH_NREG));
   assign hist_idx_o = offset[1:0];

   assign cmd_wr_o = wr_i && (acc_o == TFH_ACC_CMD);
   assign ctl_wr_o = wr_i && (acc_o == TFH_ACC_CTL);
   assign rd_go_o  = rd_i && (acc_o != TFH_ACC_NONE);

   for (genvar k = 0; k < TFH_NREG; k++) begin : g_we
      assign hist_we_o[k] = cmd_wr_o && hist_hit_o && (hist_idx_o == 2'(k));
   end

endmodule

// File: rtl/tfh_hist_reg.sv
module tfh_hist_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] cur_o,
   output logic [DATA_W-1:0] prev_o
);

   logic [DATA_W-1:0] newest_q;
   logic [DATA_W-1:0] older_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         newest_q <= '0;
         older_q  <= '0;
      end else if (we_i) begin
         older_q  <= newest_q;
         newest_q <= wdata_i;
      end
   end

   assign cur_o  = newest_q;
   assign prev_o = older_q;

endmodule

// File: rtl/tfh_devctl.sv
module tfh_devctl #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned HOB_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic              cmd_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] devctl_o,
   output logic              hob_o
);

   logic [DATA_W-1:0] ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr_i) begin
         ctl_q <= wdata_i;
      end else if (cmd_wr_i) begin
         ctl_q[HOB_BIT] <= 1'b0;
      end
   end

   assign devctl_o = ctl_q;
   assign hob_o    = ctl_q[HOB_BIT];

endmodule

// File: rtl/tfh_read_mux.sv
module tfh_read_mux
   import tfh_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          RD_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_go_i,
   input  tfh_acc_e                   acc_i,
   input  logic                       hist_hit_i,
   input  logic [1:0]                 hist_idx_i,
   input  logic                       hob_i,
   input  logic [TFH_NREG*DATA_W-1:0] cur_i,
   input  logic [TFH_NREG*DATA_W-1:0] prev_i,
   input  logic [DATA_W-1:0]          devctl_i,
   output logic [DATA_W-1:0]          rdata_o
);

   logic [DATA_W-1:0] sel_cur;
   logic [DATA_W-1:0] sel_prev;
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      sel_cur  = '0;
      sel_prev = '0;
      for (int k = 0; k < TFH_NREG; k++) begin
         if (hist_idx_i == 2'(k)) begin
            sel_cur  = cur_i[k*DATA_W +: DATA_W];
            sel_prev = prev_i[k*DATA_W +: DATA_W];
         end
      end
   end

   always_comb begin
      unique case (acc_i)
         TFH_ACC_CTL: rd_val = devctl_i;
         TFH_ACC_CMD: rd_val = !hist_hit_i ? '0 : (hob_i ? sel_prev : sel_cur);
         default:     rd_val = '0;
      endcase
   end

   if (RD_REG) begin : g_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else if (rd_go_i) begin
            rdata_q <= rd_val;
         end
      end
      assign rdata_o = rdata_q;
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ rd_go_i;
      assign rdata_o   = rd_val;
   end

endmodule

// File: rtl/hist_taskfile_regs.sv
module hist_taskfile_regs
   import tfh_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned BASE_ADDR = 2,
   parameter int unsigned HOB_BIT   = 7,
   parameter bit          RD_REG    = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_cmd_i,
   input  logic                       cs_ctl_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic                       wr_i,
   input  logic                       rd_i,
   input  logic [DATA_W-1:0]          wdata_i,
   output logic [DATA_W-1:0]          rdata_o,
   output logic [DATA_W-1:0]          devctl_o,
   output logic                       hob_o,
   output logic [TFH_NREG*DATA_W-1:0] cur_o,
   output logic [TFH_NREG*DATA_W-1:0] prev_o,
   output logic [6*DATA_W-1:0]        lba_o,
   output logic [2*DATA_W-1:0]        count_o
);

   localparam int unsigned W = DATA_W;

   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_width
      $error("hist_taskfile_regs: DATA_W must be at least 8");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("hist_taskfile_regs: ADDR_W must be at least 2");
   end
   if (BASE_ADDR + TFH_NREG > (1 << ADDR_W)) begin : g_bad_base
      $error("hist_taskfile_regs: history registers exceed the address space");
   end
   if (HOB_BIT >= DATA_W) begin : g_bad_hob
      $error("hist_taskfile_regs: HOB_BIT outside the data width");
   end

   tfh_acc_e            acc;
   logic                hist_hit;
   logic [1:0]          hist_idx;
   logic                cmd_wr;
   logic                ctl_wr;
   logic                rd_go;
   logic [TFH_NREG-1:0] hist_we;

   tfh_host_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_decode (
      .cs_cmd_i   (cs_cmd_i),
      .cs_ctl_i   (cs_ctl_i),
      .addr_i     (addr_i),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .acc_o      (acc),
      .hist_hit_o (hist_hit),
      .hist_idx_o (hist_idx),
      .cmd_wr_o   (cmd_wr),
      .ctl_wr_o   (ctl_wr),
      .rd_go_o    (rd_go),
      .hist_we_o  (hist_we)
   );

   for (genvar k = 0; k < TFH_NREG; k++) begin : g_hist
      tfh_hist_reg #(
         .DATA_W (DATA_W)
      ) u_hist (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (hist_we[k]),
         .wdata_i (wdata_i),
         .cur_o   (cur_o[k*W +: W]),
         .prev_o  (prev_o[k*W +: W])
      );
   end

   tfh_devctl #(
      .DATA_W  (DATA_W),
      .HOB_BIT (HOB_BIT)
   ) u_devctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr_i (ctl_wr),
      .cmd_wr_i (cmd_wr),
      .wdata_i  (wdata_i),
      .devctl_o (devctl_o),
      .hob_o    (hob_o)
   );

   tfh_read_mux #(
      .DATA_W (DATA_W),
      .RD_REG (RD_REG)
   ) u_rdmux (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_go_i    (rd_go),
      .acc_i      (acc),
      .hist_hit_i (hist_hit),
      .hist_idx_i (hist_idx),
      .hob_i      (hob_o),
      .cur_i      (cur_o),
      .prev_i     (prev_o),
      .devctl_i   (devctl_o),
      .rdata_o    (rdata_o)
   );

   // older bytes form the upper half of both wide values
   assign lba_o = {prev_o[int'(TFH_LBA_HI)*W +: W],
                   prev_o[int'(TFH_LBA_MID)*W +: W],
                   prev_o[int'(TFH_LBA_LO)*W +: W],
                   cur_o[int'(TFH_LBA_HI)*W +: W],
                   cur_o[int'(TFH_LBA_MID)*W +: W],
                   cur_o[int'(TFH_LBA_LO)*W +: W]};

   assign count_o = {prev_o[int'(TFH_CNT)*W +: W], cur_o[int'(TFH_CNT)*W +: W]};

endmodule

// File: rtl/tfh_checker.sv
module tfh_checker #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned BASE_ADDR = 2,
   parameter int unsigned HOB_BIT   = 7,
   parameter bit          RD_REG    = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_cmd_i,
   input logic                cs_ctl_i,
   input logic [ADDR_W-1:0]   addr_i,
   input logic                wr_i,
   input logic                rd_i,
   input logic [DATA_W-1:0]   wdata_i,
   input logic [DATA_W-1:0]   rdata_o,
   input logic [DATA_W-1:0]   devctl_o,
   input logic                hob_o,
   input logic [4*DATA_W-1:0] cur_o,
   input logic [4*DATA_W-1:0] prev_o
);

   logic cmd_only;
   logic ctl_only;
   assign cmd_only = cs_cmd_i && !cs_ctl_i;
   assign ctl_only = cs_ctl_i && !cs_cmd_i;

   for (genvar k = 0; k < 4; k++) begin : g_shift
      AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_only && wr_i && addr_i == ADDR_W'(BASE_ADDR + k))
         |=> (cur_o[k*DATA_W +: DATA_W] == $past(wdata_i) &&
              prev_o[k*DATA_W +: DATA_W] == $past(cur_o[k*DATA_W +: DATA_W])))
         else $error("history shift wrong"); // R2
   end

   AST_HOB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_only && wr_i) |=> (!hob_o &&
         ((devctl_o & ~(DATA_W'(1) << HOB_BIT)) == ($past(devctl_o) & ~(DATA_W'(1) << HOB_BIT)))))
      else $error("select bit not cleared"); // R5

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_only && wr_i) |=> (devctl_o == $past(wdata_i)))
      else $error("control load wrong"); // R6

   AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ($stable(cur_o) && $stable(prev_o) && $stable(devctl_o)))
      else $error("state changed without a write"); // R7

   AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_cmd_i == cs_ctl_i) |=> ($stable(cur_o) && $stable(prev_o) && $stable(devctl_o)))
      else $error("ignored access changed state"); // R10

   if (RD_REG) begin : g_rd_chk
      AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(rd_i && (cs_cmd_i != cs_ctl_i)) |=> $stable(rdata_o))
         else $error("read data moved without a read"); // R10

      AST_CTL_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_only && rd_i) |=> (rdata_o == $past(devctl_o)))
         else $error("control read wrong"); // R6

      AST_HIST_READ_NEW: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_only && rd_i && !hob_o && addr_i == ADDR_W'(BASE_ADDR))
         |=> (rdata_o == $past(cur_o[DATA_W-1:0])))
         else $error("newest read wrong"); // R3

      AST_HIST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_only && rd_i && hob_o && addr_i == ADDR_W'(BASE_ADDR))
         |=> (rdata_o == $past(prev_o[DATA_W-1:0])))
         else $error("older read wrong"); // R4
   end

endmodule

bind hist_taskfile_regs tfh_checker #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .HOB_BIT   (HOB_BIT),
   .RD_REG    (RD_REG)
) u_tfh_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_cmd_i (cs_cmd_i),
   .cs_ctl_i (cs_ctl_i),
   .addr_i   (addr_i),
   .wr_i     (wr_i),
   .rd_i     (rd_i),
   .wdata_i  (wdata_i),
   .rdata_o  (rdata_o),
   .devctl_o (devctl_o),
   .hob_o    (hob_o),
   .cur_o    (cur_o),
   .prev_o   (prev_o)
);

// File: tb/hist_taskfile_regs_tb_top.sv
`timescale 1ns/1ps
module hist_taskfile_regs_tb_top;

   localparam int unsigned SEED = 32'h1A2B3C4D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_cmd = 1'b0;
   logic        cs_ctl = 1'b0;
   logic [2:0]  addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [7:0]  devctl;
   logic        hob;
   logic [31:0] cur;
   logic [31:0] prev;
   logic [47:0] lba;
   logic [15:0] count;

   int checks = 0;
   int errors = 0;

   // reference model
   logic [7:0] m_cur [4];
   logic [7:0] m_prev[4];
   logic [7:0] m_dc;
   logic [7:0] m_rd;

   always #2 clk = ~clk;

   hist_taskfile_regs dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_cmd_i (cs_cmd),
      .cs_ctl_i (cs_ctl),
      .addr_i   (addr),
      .wr_i     (wr),
      .rd_i     (rd),
      .wdata_i  (wdata),
      .rdata_o  (rdata),
      .devctl_o (devctl),
      .hob_o    (hob),
      .cur_o    (cur),
      .prev_o   (prev),
      .lba_o    (lba),
      .count_o  (count)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic c_cmd, input logic c_ctl,
                                           input logic [2:0] a);
      if (c_ctl && !c_cmd) return m_dc;
      if (a >= 3'd2 && a <= 3'd5) return m_dc[7] ? m_prev[a-2] : m_cur[a-2];
      return 8'h00;
   endfunction

   function automatic string read_req(input logic c_cmd, input logic c_ctl,
                                      input logic [2:0] a);
      if (c_cmd == c_ctl) return "R10";
      if (c_ctl) return "R6";
      if (a < 3'd2 || a > 3'd5) return "R8";
      return m_dc[7] ? "R4" : "R3";
   endfunction

   task automatic chk_state(input string req);
      chk({req, " newest slots"}, 64'(cur),  64'({m_cur[3], m_cur[2], m_cur[1], m_cur[0]}));
      chk({req, " older slots"},  64'(prev), 64'({m_prev[3], m_prev[2], m_prev[1], m_prev[0]}));
      chk({req, " control"},      64'(devctl), 64'(m_dc));
      chk({req, " select bit"},   64'(hob), 64'(m_dc[7]));
      chk("R9 lba", 64'(lba),
          64'({m_prev[3], m_prev[2], m_prev[1], m_cur[3], m_cur[2], m_cur[1]}));
      chk("R9 count", 64'(count), 64'({m_prev[0], m_cur[0]}));
   endtask

   // one host cycle; read result predicted from the pre-write model (R11)
   task automatic host_op(input logic c_cmd, input logic c_ctl, input logic [2:0] a,
                          input logic w, input logic r, input logic [7:0] d,
                          input string req);
      logic [7:0] exp_rd;
      string      rreq;
      exp_rd = exp_read(c_cmd, c_ctl, a);
      rreq   = read_req(c_cmd, c_ctl, a);
      cs_cmd = c_cmd; cs_ctl = c_ctl; addr = a; wr = w; rd = r; wdata = d;
      if (r && (c_cmd != c_ctl)) m_rd = exp_rd;
      if (w && c_cmd && !c_ctl) begin
         if (a >= 3'd2 && a <= 3'd5) begin
            m_prev[a-2] = m_cur[a-2];
            m_cur[a-2]  = d;
         end
         m_dc[7] = 1'b0;
      end else if (w && c_ctl && !c_cmd) begin
         m_dc = d;
      end
      @(negedge clk);
      cs_cmd = 1'b0; cs_ctl = 1'b0; wr = 1'b0; rd = 1'b0;
      if (r) chk({rreq, " read data ", req}, 64'(rdata), 64'(m_rd));
      chk_state(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(SEED));
      for (int k = 0; k < 4; k++) begin
         m_cur[k] = '0; m_prev[k] = '0;
      end
      m_dc = '0; m_rd = '0;

      repeat (3) @(negedge clk);
      chk("R1 rdata in reset", 64'(rdata), 64'(0));
      chk_state("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata after reset", 64'(rdata), 64'(0));
      chk_state("R1 after reset");

      // R2 shift on count, R3 newest read
      host_op(1, 0, 3'd2, 1, 0, 8'h12, "R2");
      host_op(1, 0, 3'd2, 1, 0, 8'h34, "R2");
      chk("R2 newest count", 64'(cur[7:0]), 64'h34);
      chk("R2 older count", 64'(prev[7:0]), 64'h12);
      host_op(1, 0, 3'd2, 0, 1, 8'h00, "R3");
      // R12: fill LBA registers, count unchanged
      host_op(1, 0, 3'd3, 1, 0, 8'hA1, "R12");
      host_op(1, 0, 3'd4, 1, 0, 8'hB2, "R12");
      host_op(1, 0, 3'd5, 1, 0, 8'hC3, "R12");
      host_op(1, 0, 3'd3, 1, 0, 8'hD4, "R12");
      host_op(1, 0, 3'd4, 1, 0, 8'hE5, "R12");
      host_op(1, 0, 3'd5, 1, 0, 8'hF6, "R12");
      chk("R9 lba directed", 64'(lba), 64'hC3B2A1F6E5D4);
      chk("R12 count untouched", 64'(count), 64'h1234);

      // R4 older reads, R6 control load and read
      host_op(0, 1, 3'd6, 1, 0, 8'h86, "R6");
      chk("R6 control loaded", 64'(devctl), 64'h86);
      host_op(0, 1, 3'd0, 0, 1, 8'h00, "R6");
      host_op(1, 0, 3'd2, 0, 1, 8'h00, "R4");
      host_op(1, 0, 3'd5, 0, 1, 8'h00, "R4");
      // R7 repeated reads change nothing
      for (int i = 0; i < 4; i++) host_op(1, 0, 3'(2 + i), 0, 1, 8'h00, "R7");
      // R5 and R8: write to a non-history address clears only the select bit
      host_op(1, 0, 3'd7, 1, 0, 8'h5A, "R5 R8");
      chk("R5 control after cmd write", 64'(devctl), 64'h06);
      host_op(1, 0, 3'd1, 0, 1, 8'h00, "R8");
      chk("R8 non-history read is zero", 64'(rdata), 64'h00);

      // R10 both selects and neither select
      host_op(0, 1, 3'd0, 1, 0, 8'h80, "R10 setup");
      host_op(1, 0, 3'd3, 0, 1, 8'h00, "R10 setup");
      host_op(1, 1, 3'd3, 1, 1, 8'h77, "R10");
      host_op(0, 0, 3'd4, 1, 1, 8'h66, "R10");
      chk("R10 rdata held", 64'(rdata), 64'hA1);

      // R11 read and write together, select set then clear
      host_op(1, 0, 3'd4, 1, 1, 8'h99, "R11");
      chk("R11 older byte pre-write", 64'(rdata), 64'hB2);
      host_op(1, 0, 3'd4, 1, 1, 8'h88, "R11");
      chk("R11 newest byte pre-write", 64'(rdata), 64'h99);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned kind;
         logic [7:0]  d;
         logic [2:0]  a;
         kind = $urandom % 10;
         d    = 8'($urandom);
         a    = 3'($urandom);
         case (kind)
            0, 1, 2: host_op(1, 0, a, 1, 0, d, "R2 rnd");
            3, 4:    host_op(1, 0, a, 0, 1, d, "R3 R4 rnd");
            5:       host_op(0, 1, a, 1, 0, {d[0], d[6:0]}, "R6 rnd");
            6:       host_op(0, 1, a, 0, 1, d, "R6 rnd");
            7:       host_op(1, 0, a, 1, 1, d, "R11 rnd");
            8:       host_op(1, 1, a, d[0], d[1], d, "R10 rnd");
            default: host_op(0, 0, a, d[0], d[1], d, "R10 rnd");
         endcase
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule